// File: doc/BRIEF.md
# Power-of-Two Pin Debounce Filter

This block cleans up one already-synchronized input pin before its level reaches interrupt or status logic. When filtering is on, a new level is passed to the output only after the pin has held that level for a whole settling window. The window is 2^N milliseconds, where N is a 3-bit exponent, so it ranges from 1 ms to 128 ms. When filtering is off, the pin goes straight to the output.

A millisecond tick comes from a clock divider whose ratio is the parameter `CLKS_PER_MS`. The divider is restarted together with the millisecond counter, so the window always lasts exactly `2^N * CLKS_PER_MS` clock cycles from the moment the pin last changed. Any change of the pin, the exponent or the enable bit starts a new window. Converting a requested time into the exponent is left to software. Software rounds the time to the nearest power of two, so 3 ms becomes 4 ms and 96 ms becomes 128 ms.

The external active-low reset acts at once and is released through an internal two-stage synchronizer.

Top module: `pin_debounce`

## Requirements
- R1: While reset is asserted, and until the first clock edge after the internal reset release, `pin_filt` equals `pin_sync` combinationally. At that first edge the filtered state captures the pin level.
- R2: With `dbc_en` low, `pin_filt` equals `pin_sync` in the same cycle with no register delay, and the filtered state tracks the pin on every edge.
- R3: With `dbc_en` high, let W = 2^`dbc_exp` × `CLKS_PER_MS` cycles. A new pin level first sampled at edge E appears on `pin_filt` after edge E+W, provided the level, `dbc_en` and `dbc_exp` stay unchanged through that edge. Before then, `pin_filt` keeps the old level.
- R4: A level held for exactly W sampling edges, then withdrawn, leaves `pin_filt` unchanged.
- R5: Any change of the pin level restarts the window. A pin that keeps toggling faster than W never changes `pin_filt`.
- R6: `dbc_exp` is an unsigned 3-bit field. Values 0 through 7 select windows of 1, 2, 4, 8, 16, 32, 64 and 128 ms, and the millisecond count never exceeds 2^exponent − 1.
- R7: A change of `dbc_exp` or `dbc_en` restarts the window. `pin_filt` keeps its value until a level has been stable for the full new window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_sync | input | 1 | Pin level, already synchronized to `clk` |
| dbc_en | input | 1 | 1 = debounce on, 0 = pass-through |
| dbc_exp | input | EXP_W | Window exponent N, window = 2^N ms |
| pin_filt | output | 1 | Filtered pin level |

## Verification
Single clean steps are placed against the exponents 0, 2 and 7. This shows whether the window length scales by powers of two and whether the update lands on exactly the cycle after the last window edge. A pulse held one edge too short separates a correct window from one that is off by one. A pin toggling faster than the window shows whether every change restarts the count. Switching the exponent in the middle of a window shows whether the old partial count is wrongly credited. Toggling with the filter off shows whether the bypass adds a register stage.

// File: rtl/pin_debounce_pkg.sv
package pin_debounce_pkg;

  // Default exponent width: 3 bits selects 1..128 ms windows.
  parameter int DBC_EXP_W_DEF = 3;

  // Width of a counter that must reach 2^(2^exp_w - 1) - 1.
  function automatic int ms_count_width(input int exp_w);
    return (1 << exp_w) - 1;
  endfunction

  // Width of the clock divider counter.
  function automatic int div_width(input int clks);
    return (clks > 1) ? $clog2(clks) : 1;
  endfunction

  typedef enum logic [1:0] {
    DBC_IDLE   = 2'd0,
    DBC_COUNT  = 2'd1,
    DBC_ACCEPT = 2'd2,
    DBC_FLUSH  = 2'd3
  } dbc_phase_e;

endpackage

// File: rtl/dbc_rst_sync.sv
module dbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dbc_ms_divider.sv
module dbc_ms_divider
  import pin_debounce_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);

  localparam int DIV_W = div_width(CLKS_PER_MS);
  localparam logic [DIV_W-1:0] LAST = DIV_W'(CLKS_PER_MS - 1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    if (restart)      cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = at_last && !restart;

endmodule

// File: rtl/dbc_settle_timer.sv
module dbc_settle_timer
  import pin_debounce_pkg::*;
#(
  parameter int EXP_W = DBC_EXP_W_DEF
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 restart,
  input  logic                                 tick,
  input  logic [EXP_W-1:0]                     exp_sel,
  output logic                                 done,
  output logic [ms_count_width(EXP_W)-1:0]     ms_cnt
);

  localparam int MS_W = ms_count_width(EXP_W);

  logic [MS_W-1:0] cnt_q;
  logic [MS_W-1:0] cnt_d;
  logic [MS_W-1:0] last_ms;

  // last_ms = 2^exp_sel - 1 is a thermometer code in the exponent.
  for (genvar i = 0; i < MS_W; i++) begin : g_therm
    assign last_ms[i] = (exp_sel > EXP_W'(i));
  end

  assign done = tick && (cnt_q == last_ms);

  always_comb begin
    if (restart)   cnt_d = '0;
    else if (done) cnt_d = '0;
    else if (tick) cnt_d = cnt_q + MS_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ms_cnt = cnt_q;

endmodule

// File: rtl/pin_debounce.sv
module pin_debounce
  import pin_debounce_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000,
  parameter int EXP_W       = DBC_EXP_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_sync,
  input  logic             dbc_en,
  input  logic [EXP_W-1:0] dbc_exp,
  output logic             pin_filt
);

  localparam int MS_W = ms_count_width(EXP_W);

  logic             rst_sync_n;
  logic             primed_q, primed_d;
  logic             cand_q,   cand_d;
  logic             filt_q,   filt_d;
  logic             en_q,     en_d;
  logic [EXP_W-1:0] exp_q,    exp_d;
  logic             pin_chg;
  logic             cfg_chg;
  logic             restart;
  logic             tick;
  logic             done;
  logic [MS_W-1:0]  settle_ms;
  dbc_phase_e       phase;

  dbc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign pin_chg = (pin_sync != cand_q);
  assign cfg_chg = (dbc_en != en_q) || (dbc_exp != exp_q);
  assign restart = !primed_q || pin_chg || cfg_chg;

  dbc_ms_divider #(.CLKS_PER_MS(CLKS_PER_MS)) u_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (restart),
    .tick    (tick)
  );

  dbc_settle_timer #(.EXP_W(EXP_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (restart),
    .tick    (tick),
    .exp_sel (dbc_exp),
    .done    (done),
    .ms_cnt  (settle_ms)
  );

  always_comb begin
    if (!primed_q)    phase = DBC_IDLE;
    else if (!dbc_en) phase = DBC_FLUSH;
    else if (done)    phase = DBC_ACCEPT;
    else              phase = DBC_COUNT;
  end

  always_comb begin
    primed_d = 1'b1;
    cand_d   = pin_sync;
    en_d     = dbc_en;
    exp_d    = dbc_exp;
    case (phase)
      DBC_IDLE:   filt_d = pin_sync;
      DBC_FLUSH:  filt_d = pin_sync;
      DBC_ACCEPT: filt_d = pin_sync;
      default:    filt_d = filt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      primed_q <= 1'b0;
      cand_q   <= 1'b0;
      filt_q   <= 1'b0;
      en_q     <= 1'b0;
      exp_q    <= '0;
    end else begin
      primed_q <= primed_d;
      cand_q   <= cand_d;
      filt_q   <= filt_d;
      en_q     <= en_d;
      exp_q    <= exp_d;
    end
  end

  assign pin_filt = (primed_q && dbc_en) ? filt_q : pin_sync;

endmodule

// File: rtl/pin_debounce_chk.sv
module pin_debounce_chk #(
  parameter int EXP_W = 3,
  parameter int MS_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pin_sync,
  input logic             dbc_en,
  input logic [EXP_W-1:0] dbc_exp,
  input logic             primed,
  input logic             filt,
  input logic             restart,
  input logic             en_q,
  input logic [EXP_W-1:0] exp_q,
  input logic [MS_W-1:0]  ms_cnt
);

  logic cfg_moved;
  assign cfg_moved = (dbc_en != en_q) || (dbc_exp != exp_q);

  AST_PRIME_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(primed) |-> filt == $past(pin_sync)); // R1

  AST_OFF_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(primed) && !$past(dbc_en)) |-> filt == $past(pin_sync)); // R2

  AST_CHANGE_ADOPTS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(primed) && filt != $past(filt)) |-> filt == $past(pin_sync)); // R3

  AST_RESTART_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && restart && dbc_en) |=> $stable(filt)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (int'(ms_cnt) < (1 << exp_q))); // R6

  AST_CFG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && cfg_moved) |=> ms_cnt == '0); // R7

endmodule

bind pin_debounce pin_debounce_chk #(.EXP_W(EXP_W), .MS_W(MS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .pin_sync (pin_sync),
  .dbc_en   (dbc_en),
  .dbc_exp  (dbc_exp),
  .primed   (primed_q),
  .filt     (filt_q),
  .restart  (restart),
  .en_q     (en_q),
  .exp_q    (exp_q),
  .ms_cnt   (settle_ms)
);

// File: tb/pin_debounce_test.sv
`timescale 1ns/1ps
module pin_debounce_test;

  localparam int CPM = 3;

  logic       clk;
  logic       rst_n;
  logic       pin;
  logic       en;
  logic [2:0] expo;
  logic       pin_filt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_run = 0;

  pin_debounce #(.CLKS_PER_MS(CPM), .EXP_W(3)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_sync (pin),
    .dbc_en   (en),
    .dbc_exp  (expo),
    .pin_filt (pin_filt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Behavioural reference: one integer counts stable cycles.
  bit   model_on = 0;
  logic m_filt;
  logic m_prev_pin;
  logic m_prev_en;
  logic [2:0] m_prev_exp;
  int   m_cnt;

  always @(posedge clk) begin
    if (model_on) begin
      bit rs;
      rs = (pin != m_prev_pin) || (en != m_prev_en) || (expo != m_prev_exp);
      if (!en) m_filt = pin;
      if (rs) m_cnt = 0;
      else begin
        m_cnt++;
        if (m_cnt == (1 << expo) * CPM) begin
          if (en) m_filt = pin;
          m_cnt = 0;
        end
      end
      m_prev_pin = pin;
      m_prev_en  = en;
      m_prev_exp = expo;
    end
  end

  always @(posedge clk) begin
    #5;
    if (model_on) chk("R3 model compare", pin_filt, en ? m_filt : pin);
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive a new level, check the old one holds for w edges and the new one follows.
  task automatic window(input string tag, input logic newv, input int w);
    logic oldv;
    oldv = pin_filt;
    pin = newv;
    for (int k = 0; k < w; k++) begin
      step(1);
      chk(tag, pin_filt, oldv);
    end
    step(1);
    chk(tag, pin_filt, newv);
  endtask

  initial begin
    rst_n = 1'b0;
    pin   = 1'b1;
    en    = 1'b1;
    expo  = 3'd0;
    #1;
    chk("R1 reset pass high", pin_filt, 1'b1);
    pin = 1'b0;
    #1;
    chk("R1 reset pass low", pin_filt, 1'b0);
    pin = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 after release", pin_filt, 1'b1);
    step(5);
    chk("R1 captured level", pin_filt, 1'b1);
    m_filt = pin; m_prev_pin = pin; m_prev_en = en; m_prev_exp = expo; m_cnt = 0;
    model_on = 1;

    // R6 smallest window, R3 exact update cycle
    window("R3 exp0 fall", 1'b0, 1 * CPM);
    window("R6 exp0 rise", 1'b1, 1 * CPM);

    // R4: held exactly W edges then withdrawn
    expo = 3'd2;
    step(2);
    pin = 1'b0;
    for (int k = 0; k < 4 * CPM; k++) begin
      step(1);
      chk("R4 short pulse", pin_filt, 1'b1);
    end
    pin = 1'b1;
    for (int k = 0; k < 4 * CPM + 2; k++) begin
      step(1);
      chk("R4 after pulse", pin_filt, 1'b1);
    end
    window("R3 exp2 fall", 1'b0, 4 * CPM);

    // R5: bouncing faster than the window
    expo = 3'd1;
    step(1);
    for (int b = 0; b < 10; b++) begin
      pin = ~pin;
      for (int k = 0; k < 3; k++) begin
        step(1);
        chk("R5 bounce", pin_filt, 1'b0);
      end
    end
    pin = 1'b0;
    step(2 * CPM + 2);
    chk("R5 settled", pin_filt, 1'b0);

    // R7: exponent change mid-window restarts the count
    expo = 3'd2;
    step(2);
    pin = 1'b1;
    for (int k = 0; k < 8; k++) begin
      step(1);
      chk("R7 before cfg change", pin_filt, 1'b0);
    end
    expo = 3'd1;
    for (int k = 0; k < 2 * CPM; k++) begin
      step(1);
      chk("R7 new window hold", pin_filt, 1'b0);
    end
    step(1);
    chk("R7 new window done", pin_filt, 1'b1);

    // R2: bypass with no delay
    en = 1'b0;
    #1;
    chk("R2 bypass level", pin_filt, 1'b1);
    for (int k = 0; k < 4; k++) begin
      step(1);
      pin = ~pin;
      #1;
      chk("R2 bypass same cycle", pin_filt, pin);
    end
    step(1);
    pin = 1'b0;
    step(2);
    en = 1'b1;
    #1;
    chk("R7 enable keeps level", pin_filt, 1'b0);
    step(2);

    // R6 largest window
    expo = 3'd7;
    step(2);
    window("R6 exp7 rise", 1'b1, 128 * CPM);
    step(4);

    finish_run();
  end

endmodule